// File: doc/BRIEF.md
# Banked I/O Register Access Port

This block connects a processor core to external I/O registers. The registers sit in banks of eight, so the core names a register by an 8-bit bank number and a 3-bit index within that bank. When the core asks for a read or a write, the port drives a flat register address, a read/write line, the write data and a request strobe onto separate bus lines. No line is shared between address and data. All of these lines hold still for the whole access.

The port keeps the core stalled for as long as the device needs. The access ends only when the device raises its completion line. That line is asynchronous to the port's clock, so it passes through a synchroniser before any logic uses it. The port then drops the strobe, returns any read data with a one-cycle done pulse, and waits for the completion line to fall before it accepts another request. This is a four-phase handshake.

An optional timeout guards against a device that never answers. When the programmed limit is non-zero and the strobe has been up that many cycles without an answer, the access is abandoned and an error pulse is given instead of the done pulse.

Top module: `bankio_port`

## Requirements
- R1: After reset, `bus_strobe`, `core_busy`, `core_done` and `core_err` are low and `core_rdata` is zero.
- R2: A `core_req` that is high at a rising edge while `core_busy` is low starts an access at that edge. From that edge, `bus_strobe` and `core_busy` are high. `bus_addr` carries the bank in bits [10:3] and the register index in bits [2:0]. `bus_wr` is 1 for a write and 0 for a read. `bus_wdata` carries the write data on a write and zero on a read.
- R3: While `bus_strobe` stays high, `bus_addr`, `bus_wr` and `bus_wdata` do not change.
- R4: When `timeout_limit` is zero, `bus_strobe` stays high for as long as `bus_done` stays low, with no upper bound.
- R5: `bus_done` is synchronised through two flops. `core_done` pulses for exactly one cycle starting at the third rising edge after `bus_done` rises. `bus_strobe` falls at that same edge.
- R6: On a read, `bus_rdata` is captured into `core_rdata` at the edge where `core_done` rises. A write leaves `core_rdata` unchanged.
- R7: After an access ends, `core_busy` stays high until the third rising edge after `bus_done` falls. A `core_req` raised while `core_busy` is high is ignored and starts no later access.
- R8: With `timeout_limit` = L > 0 and `bus_done` held low, `bus_strobe` stays high for exactly L cycles. It then falls, and `core_err` pulses for one cycle, with no `core_done` pulse and no change to `core_rdata`.
- R9: If `bus_done` arrives before the limit expires, the access completes normally and `core_err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req | input | 1 | Access request from the core, sampled when not busy |
| core_wr | input | 1 | 1 = write, 0 = read |
| core_bank | input | 8 | Bank number |
| core_reg | input | 3 | Register index inside the bank |
| core_wdata | input | 16 | Write data |
| timeout_limit | input | 16 | Strobe cycles before abort; 0 disables the timeout |
| core_busy | output | 1 | Stall to the core while an access is in flight |
| core_done | output | 1 | One-cycle pulse when an access completes |
| core_err | output | 1 | One-cycle pulse when an access times out |
| core_rdata | output | 16 | Data returned by the last completed read |
| bus_addr | output | 11 | Flat register address {bank, index} |
| bus_wr | output | 1 | Read/write line |
| bus_wdata | output | 16 | Write data driven to the bus |
| bus_strobe | output | 1 | I/O request strobe |
| bus_rdata | input | 16 | Read data from the device |
| bus_done | input | 1 | Asynchronous completion from the device |

## Verification
The bus outputs appear at the same edge that accepts the request. The done pulse and the strobe's fall come three edges after the completion line rises: two synchroniser flops and then the state register. The release of busy also comes three edges after the completion line falls. A timeout ends the strobe after exactly the programmed number of cycles. The bench changes inputs on falling edges and samples on falling edges. It counts falling edges from each stimulus and checks every output at the exact count where it is due, and also at the count just before, so an extra or a missing register stage shows up as a mismatch.

// File: rtl/bankio_pkg.sv
package bankio_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_REL  = 2'd2
   } bio_state_t;

endpackage

// File: rtl/bankio_sync.sv
module bankio_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("bankio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain <= {chain[STAGES-2:0], d_async};
      end
   end

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/bankio_timer.sv
module bankio_timer #(
   parameter int TO_W = 16,
   parameter bit EN   = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [TO_W-1:0] limit,
   output logic            expire
);

   if (TO_W < 1) begin : g_bad_width
      $error("bankio_timer: TO_W must be at least 1");
   end

   if (EN) begin : g_timer
      logic [TO_W-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (run) begin
            cnt <= cnt + 1'b1;
         end else begin
            cnt <= '0;
         end
      end

      assign expire = run && (limit != '0) && (cnt == limit - 1'b1);

      // a zero limit never aborts an access (R4)
      assert_zero_limit_never_expires_R4 : assert property (
         @(posedge clk) disable iff (!rst_n)
         (limit == '0) |-> !expire);

      // the count never runs past the limit (R8)
      assert_count_within_limit_R8 : assert property (
         @(posedge clk) disable iff (!rst_n)
         (run && limit != '0) |-> (cnt < limit));
   end else begin : g_no_timer
      logic unused_timer;
      assign unused_timer = ^{clk, rst_n, run, limit};
      assign expire = 1'b0;
   end

endmodule

// File: rtl/bankio_port.sv
module bankio_port
   import bankio_pkg::*;
#(
   parameter int BANK_W      = 8,
   parameter int REG_W       = 3,
   parameter int DATA_W      = 16,
   parameter int TO_W        = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit TIMEOUT_EN  = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    core_req,
   input  logic                    core_wr,
   input  logic [BANK_W-1:0]       core_bank,
   input  logic [REG_W-1:0]        core_reg,
   input  logic [DATA_W-1:0]       core_wdata,
   input  logic [TO_W-1:0]         timeout_limit,
   output logic                    core_busy,
   output logic                    core_done,
   output logic                    core_err,
   output logic [DATA_W-1:0]       core_rdata,
   output logic [BANK_W+REG_W-1:0] bus_addr,
   output logic                    bus_wr,
   output logic [DATA_W-1:0]       bus_wdata,
   output logic                    bus_strobe,
   input  logic [DATA_W-1:0]       bus_rdata,
   input  logic                    bus_done
);

   localparam int ADDR_W = BANK_W + REG_W;

   if (BANK_W < 1 || REG_W < 1 || DATA_W < 1) begin : g_bad_widths
      $error("bankio_port: widths must be at least 1");
   end
   if (ADDR_W > 32) begin : g_bad_addr
      $error("bankio_port: address wider than 32 bits");
   end

   bio_state_t state;
   logic       done_s;
   logic       expire;

   bankio_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (bus_done),
      .q_sync  (done_s)
   );

   bankio_timer #(.TO_W(TO_W), .EN(TIMEOUT_EN)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (state == ST_REQ),
      .limit  (timeout_limit),
      .expire (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         bus_addr   <= '0;
         bus_wr     <= 1'b0;
         bus_wdata  <= '0;
         bus_strobe <= 1'b0;
         core_done  <= 1'b0;
         core_err   <= 1'b0;
         core_rdata <= '0;
      end else begin
         core_done <= 1'b0;
         core_err  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (core_req) begin
                  bus_addr   <= {core_bank, core_reg};
                  bus_wr     <= core_wr;
                  bus_wdata  <= core_wr ? core_wdata : '0;
                  bus_strobe <= 1'b1;
                  state      <= ST_REQ;
               end
            end
            ST_REQ: begin
               if (done_s) begin
                  bus_strobe <= 1'b0;
                  core_done  <= 1'b1;
                  if (!bus_wr) begin
                     core_rdata <= bus_rdata;
                  end
                  state <= ST_REL;
               end else if (expire) begin
                  bus_strobe <= 1'b0;
                  core_err   <= 1'b1;
                  state      <= ST_REL;
               end
            end
            ST_REL: begin
               if (!done_s) begin
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign core_busy = (state != ST_IDLE);

   // bus lines hold while the strobe is up (R3)
   assert_bus_stable_R3 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (bus_strobe && $past(bus_strobe)) |->
         ($stable(bus_addr) && $stable(bus_wr) && $stable(bus_wdata)));

   // completion is a single-cycle pulse (R5)
   assert_done_pulse_R5 : assert property (
      @(posedge clk) disable iff (!rst_n)
      core_done |=> !core_done);

   // the strobe is down once the core is told the access ended (R5)
   assert_strobe_low_at_done_R5 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (core_done || core_err) |-> !bus_strobe);

   // a new strobe never starts while completion is still high (R7)
   assert_four_phase_R7 : assert property (
      @(posedge clk) disable iff (!rst_n)
      $rose(bus_strobe) |-> !done_s);

   // error and done never together (R8)
   assert_err_excl_R8 : assert property (
      @(posedge clk) disable iff (!rst_n)
      !(core_done && core_err));

   // strobe implies the core is stalled (R2)
   assert_busy_cover_R2 : assert property (
      @(posedge clk) disable iff (!rst_n)
      bus_strobe |-> core_busy);

endmodule

// File: tb/bankio_port_test.sv
module bankio_port_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        core_req = 1'b0;
   logic        core_wr = 1'b0;
   logic [7:0]  core_bank = '0;
   logic [2:0]  core_reg = '0;
   logic [15:0] core_wdata = '0;
   logic [15:0] timeout_limit = '0;
   logic        core_busy, core_done, core_err;
   logic [15:0] core_rdata;
   logic [10:0] bus_addr;
   logic        bus_wr;
   logic [15:0] bus_wdata;
   logic        bus_strobe;
   logic [15:0] bus_rdata = '0;
   logic        bus_done = 1'b0;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   bankio_port uut (
      .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_wr(core_wr),
      .core_bank(core_bank), .core_reg(core_reg), .core_wdata(core_wdata),
      .timeout_limit(timeout_limit), .core_busy(core_busy),
      .core_done(core_done), .core_err(core_err), .core_rdata(core_rdata),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_strobe(bus_strobe), .bus_rdata(bus_rdata), .bus_done(bus_done)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<100000", cycles);
         finish_run();
      end
   end

   // issue a one-cycle request; on return the access has been accepted
   task automatic start(input logic wr, input logic [7:0] bank,
                        input logic [2:0] rg, input logic [15:0] wd);
      core_req = 1'b1; core_wr = wr; core_bank = bank; core_reg = rg;
      core_wdata = wd;
      @(negedge clk);
      core_req = 1'b0;
   endtask

   // raise done, check the pulse lands on the third edge, then release
   task automatic complete(input string tag);
      bus_done = 1'b1;
      for (int i = 1; i <= 3; i++) begin
         @(negedge clk);
         chk({tag, " R5 done"}, core_done, (i == 3));
         chk({tag, " R5 strobe"}, bus_strobe, (i < 3));
      end
      @(negedge clk);
      chk({tag, " R5 pulse width"}, core_done, 0);
      bus_done = 1'b0;
      for (int i = 1; i <= 3; i++) begin
         @(negedge clk);
         chk({tag, " R7 busy release"}, core_busy, (i < 3));
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 strobe", bus_strobe, 0);
      chk("R1 busy", core_busy, 0);
      chk("R1 done", core_done, 0);
      chk("R1 err", core_err, 0);
      chk("R1 rdata", core_rdata, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_write();
      start(1'b1, 8'hA5, 3'd6, 16'hBEEF);
      chk("R2 write strobe", bus_strobe, 1);
      chk("R2 write busy", core_busy, 1);
      chk("R2 write addr", bus_addr, {8'hA5, 3'd6});
      chk("R2 write wr", bus_wr, 1);
      chk("R2 write data", bus_wdata, 16'hBEEF);
      core_wdata = 16'h0000;
      core_bank = 8'h00;
      repeat (4) @(negedge clk);
      chk("R3 addr held", bus_addr, {8'hA5, 3'd6});
      chk("R3 data held", bus_wdata, 16'hBEEF);
      bus_rdata = 16'h1111;
      complete("write");
      chk("R6 write keeps rdata", core_rdata, 0);
   endtask

   task automatic t_read();
      start(1'b0, 8'h3C, 3'd1, 16'hFFFF);
      chk("R2 read addr", bus_addr, {8'h3C, 3'd1});
      chk("R2 read wr", bus_wr, 0);
      chk("R2 read wdata zero", bus_wdata, 0);
      bus_rdata = 16'h5A3C;
      complete("read");
      chk("R6 read data", core_rdata, 16'h5A3C);
      chk("R1 no err on read", core_err, 0);
   endtask

   task automatic t_long_wait();
      timeout_limit = 16'd0;
      start(1'b0, 8'hFF, 3'd7, 16'h0);
      chk("R2 max addr", bus_addr, 11'h7FF);
      repeat (300) @(negedge clk);
      chk("R4 strobe still high", bus_strobe, 1);
      chk("R4 no err", core_err, 0);
      bus_rdata = 16'h0042;
      complete("long");
      chk("R6 long read data", core_rdata, 16'h0042);
   endtask

   task automatic t_ignore_busy();
      start(1'b1, 8'h12, 3'd2, 16'h7777);
      start(1'b0, 8'h99, 3'd5, 16'h0);
      chk("R7 addr unchanged", bus_addr, {8'h12, 3'd2});
      chk("R7 wr unchanged", bus_wr, 1);
      bus_done = 1'b1;
      repeat (3) @(negedge clk);
      start(1'b0, 8'h55, 3'd3, 16'h0);
      bus_done = 1'b0;
      repeat (3) @(negedge clk);
      chk("R7 idle after release", core_busy, 0);
      repeat (4) @(negedge clk);
      chk("R7 no extra strobe", bus_strobe, 0);
      chk("R7 addr kept", bus_addr, {8'h12, 3'd2});
   endtask

   task automatic t_timeout(input int lim);
      int high;
      int errs;
      int dones;
      high = 0; errs = 0; dones = 0;
      timeout_limit = 16'(lim);
      start(1'b0, 8'h07, 3'd0, 16'h0);
      for (int i = 0; i < lim + 6; i++) begin
         if (bus_strobe) high++;
         if (core_err) errs++;
         if (core_done) dones++;
         if (i == lim) chk("R8 err at expiry", core_err, 1);
         @(negedge clk);
      end
      chk("R8 strobe cycles", high, lim);
      chk("R8 single err pulse", errs, 1);
      chk("R8 no done", dones, 0);
      chk("R8 rdata unchanged", core_rdata, 16'h0042);
      chk("R8 idle after abort", core_busy, 0);
   endtask

   task automatic t_done_beats_timeout();
      int errs;
      errs = 0;
      timeout_limit = 16'd10;
      start(1'b0, 8'h21, 3'd4, 16'h0);
      repeat (3) @(negedge clk);
      bus_rdata = 16'hC0DE;
      bus_done = 1'b1;
      for (int i = 0; i < 12; i++) begin
         if (core_err) errs++;
         if (i == 4) bus_done = 1'b0;
         @(negedge clk);
      end
      chk("R9 no err", errs, 0);
      chk("R9 read data", core_rdata, 16'hC0DE);
      chk("R9 idle", core_busy, 0);
      timeout_limit = 16'd0;
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_write();
      t_read();
      t_long_wait();
      t_ignore_busy();
      t_timeout(1);
      t_timeout(7);
      t_done_beats_timeout();
      finish_run();
   end

endmodule